// File: doc/BRIEF.md
# Age-Ordered Reservation Station

This block parks decoded operations in front of a single execution unit until their source operands can be delivered. Each cycle it can take one new operation from the issue stage, listens to a result-tag broadcast to learn which pending operands have been produced, and sends at most one waiting operation to its unit. The default build holds eight operations.

Selection works in two tiers. An operation whose sources are all ready is always preferred over one that is only eligible because a source was announced as arriving one cycle early. Within the chosen tier, the operation that entered the station first wins, whatever slot it sits in. Early dispatch is flagged on the dispatch port, so the unit can tell it apart from a normal dispatch. A flush input empties the station in one cycle. Recovery from a wrong early dispatch is left to the surrounding pipeline.

Top module: `rs_station`

## Requirements
- R1: One operation is accepted per cycle into the lowest-numbered free slot. Source s occupies bits [s*TAG_W +: TAG_W] of `alloc_src_tag` and bit s of `alloc_src_rdy`. `alloc_full` is high exactly when every slot is occupied, and an allocate request in that state is dropped.
- R2: At most one operation leaves per cycle on the dispatch port. `disp_valid` reflects the stored state. The dispatched slot becomes free at the next rising clock edge.
- R3: Among candidates of the same tier, the operation allocated earliest is dispatched, independent of slot index.
- R4: An entry with every source ready takes priority over an entry that depends on an early-announced source, even when the latter is older.
- R5: A broadcast with `wk_valid`=1, `wk_early`=0 and a tag equal to a waiting source marks that source ready from the next cycle on.
- R6: A broadcast with `wk_early`=1 and a matching tag makes the entry eligible from the next cycle. If it is dispatched in that state, `disp_spec`=1. One cycle later the source counts as fully ready.
- R7: A broadcast in the same cycle as an allocation applies to the sources of the incoming operation.
- R8: `flush` empties every slot at the next edge, and an allocate request in the flush cycle is dropped.
- R9: After reset the station is empty: `disp_valid`=0 and `alloc_full`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Squash all held operations |
| alloc_valid | input | 1 | New operation offered |
| alloc_payload | input | PAYLOAD_W | Opaque operation body |
| alloc_src_tag | input | NUM_SRC*TAG_W | Producer tag of each source |
| alloc_src_rdy | input | NUM_SRC | Source already available |
| alloc_full | output | 1 | No free slot; allocation is dropped |
| wk_valid | input | 1 | Result tag broadcast valid |
| wk_tag | input | TAG_W | Broadcast producer tag |
| wk_early | input | 1 | Result arrives one cycle after this broadcast |
| disp_valid | output | 1 | An operation is sent this cycle |
| disp_payload | output | PAYLOAD_W | Body of the sent operation |
| disp_spec | output | 1 | Sent on an early-announced operand |

## Verification
The bench builds the station with four slots, two sources, four-bit tags and eight-bit payloads. The small depth lets a short sequence fill every slot, so dropped allocation and draining from full can be checked. With only four slots, free slots are reused out of index order, which shows that age and slot number are independent. The vector table also sets up an older entry that waits on an early announcement beside a younger entry that is fully ready, to check tier priority. Same-cycle wakeup on allocation and flush-with-allocate are covered as well.

// File: rtl/rs_pkg.sv
package rs_pkg;

   // Readiness of one source operand
   typedef enum logic [1:0] {
      SRC_WAIT  = 2'd0,
      SRC_SPEC  = 2'd1,
      SRC_READY = 2'd2
   } src_state_e;

   // State reached by a waiting source on a matching broadcast
   function automatic src_state_e on_wake(input logic early);
      return early ? SRC_SPEC : SRC_READY;
   endfunction

endpackage

// File: rtl/rs_first_one.sv
module rs_first_one #(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] onehot,
   output logic         any
);

   if (N < 1) begin : g_bad_n
      $error("rs_first_one: N must be at least 1");
   end

   always_comb begin
      onehot = '0;
      any    = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            onehot[i] = 1'b1;
            any       = 1'b1;
         end
      end
   end

endmodule

// File: rtl/rs_age_matrix.sv
module rs_age_matrix #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] alloc_we,
   input  logic [N-1:0] valid,
   input  logic [N-1:0] req,
   output logic [N-1:0] oldest
);

   if (N < 2) begin : g_bad_n
      $error("rs_age_matrix: N must be at least 2");
   end

   // older_q[i][j] = 1 : slot i was allocated before slot j
   logic [N-1:0] older_q [N];
   logic [N-1:0] blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) older_q[i] <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
               if (i != j) begin
                  if (alloc_we[i])      older_q[i][j] <= 1'b0;
                  else if (alloc_we[j]) older_q[i][j] <= 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         blocked[i] = 1'b0;
         for (int j = 0; j < N; j++) begin
            if (j != i && req[j] && older_q[j][i]) blocked[i] = 1'b1;
         end
         oldest[i] = req[i] && !blocked[i];
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_ord_i
      for (genvar j = i + 1; j < N; j++) begin : g_ord_j
         AST_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            (valid[i] && valid[j]) |-> (older_q[i][j] != older_q[j][i])); // R3
      end
   end

endmodule

// File: rtl/rs_entry.sv
module rs_entry
   import rs_pkg::*;
#(
   parameter int NUM_SRC   = 2,
   parameter int TAG_W     = 6,
   parameter int PAYLOAD_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     alloc_we,
   input  logic [PAYLOAD_W-1:0]     alloc_payload,
   input  logic [NUM_SRC*TAG_W-1:0] alloc_tags,
   input  logic [NUM_SRC-1:0]       alloc_rdy,
   input  logic                     wk_valid,
   input  logic [TAG_W-1:0]         wk_tag,
   input  logic                     wk_early,
   input  logic                     grant,
   output logic                     valid,
   output logic [PAYLOAD_W-1:0]     payload,
   output logic                     all_ready,
   output logic                     spec_ok
);

   localparam int TAGS_W = NUM_SRC * TAG_W;

   logic                 valid_q;
   logic [PAYLOAD_W-1:0] payload_q;
   logic [TAGS_W-1:0]    tags_q;
   logic [NUM_SRC-1:0]   src_ready;
   logic [NUM_SRC-1:0]   src_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         payload_q <= '0;
         tags_q    <= '0;
      end else begin
         if (flush)         valid_q <= 1'b0;
         else if (alloc_we) valid_q <= 1'b1;
         else if (grant)    valid_q <= 1'b0;
         if (alloc_we) begin
            payload_q <= alloc_payload;
            tags_q    <= alloc_tags;
         end
      end
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      src_state_e       st_q;
      src_state_e       st_d;
      logic [TAG_W-1:0] held_tag;
      logic [TAG_W-1:0] new_tag;
      logic             hit_held;
      logic             hit_new;

      assign held_tag = tags_q[s*TAG_W +: TAG_W];
      assign new_tag  = alloc_tags[s*TAG_W +: TAG_W];
      assign hit_held = wk_valid && (held_tag == wk_tag);
      assign hit_new  = wk_valid && (new_tag == wk_tag);

      always_comb begin
         st_d = st_q;
         if (alloc_we) begin
            if (alloc_rdy[s])  st_d = SRC_READY;
            else if (hit_new)  st_d = on_wake(wk_early);
            else               st_d = SRC_WAIT;
         end else begin
            unique case (st_q)
               SRC_WAIT:  if (hit_held) st_d = on_wake(wk_early);
               SRC_SPEC:  st_d = SRC_READY;
               SRC_READY: st_d = SRC_READY;
               default:   st_d = SRC_WAIT;
            endcase
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= SRC_WAIT;
         else        st_q <= st_d;
      end

      assign src_ready[s] = (st_q == SRC_READY);
      assign src_go[s]    = (st_q == SRC_READY) || (st_q == SRC_SPEC);

      AST_SPEC_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_q && st_q == SRC_SPEC && !flush && !grant) |=> (st_q == SRC_READY)); // R6
   end

   assign valid     = valid_q;
   assign payload   = payload_q;
   assign all_ready = valid_q && (&src_ready);
   assign spec_ok   = valid_q && (&src_go) && !(&src_ready);

   AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_we |-> !valid_q); // R1

endmodule

// File: rtl/rs_station.sv
module rs_station
   import rs_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int NUM_SRC     = 2,
   parameter int TAG_W       = 6,
   parameter int PAYLOAD_W   = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     alloc_valid,
   input  logic [PAYLOAD_W-1:0]     alloc_payload,
   input  logic [NUM_SRC*TAG_W-1:0] alloc_src_tag,
   input  logic [NUM_SRC-1:0]       alloc_src_rdy,
   output logic                     alloc_full,
   input  logic                     wk_valid,
   input  logic [TAG_W-1:0]         wk_tag,
   input  logic                     wk_early,
   output logic                     disp_valid,
   output logic [PAYLOAD_W-1:0]     disp_payload,
   output logic                     disp_spec
);

   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("rs_station: NUM_ENTRIES must be at least 2");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("rs_station: NUM_SRC must be at least 1");
   end
   if (TAG_W < 1 || PAYLOAD_W < 1) begin : g_bad_width
      $error("rs_station: TAG_W and PAYLOAD_W must be positive");
   end

   logic [NUM_ENTRIES-1:0] valid;
   logic [NUM_ENTRIES-1:0] free_slots;
   logic [NUM_ENTRIES-1:0] free_onehot;
   logic [NUM_ENTRIES-1:0] alloc_we;
   logic [NUM_ENTRIES-1:0] ready_mask;
   logic [NUM_ENTRIES-1:0] spec_mask;
   logic [NUM_ENTRIES-1:0] pick_req;
   logic [NUM_ENTRIES-1:0] grant;
   logic [PAYLOAD_W-1:0]   ent_payload [NUM_ENTRIES];
   logic                   any_free;
   logic                   any_ready;

   assign free_slots = ~valid;

   rs_first_one #(.N(NUM_ENTRIES)) u_free (
      .req    (free_slots),
      .onehot (free_onehot),
      .any    (any_free)
   );

   assign alloc_full = !any_free;
   assign alloc_we   = (alloc_valid && !flush) ? free_onehot : '0;

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      rs_entry #(
         .NUM_SRC   (NUM_SRC),
         .TAG_W     (TAG_W),
         .PAYLOAD_W (PAYLOAD_W)
      ) u_entry (
         .clk           (clk),
         .rst_n         (rst_n),
         .flush         (flush),
         .alloc_we      (alloc_we[e]),
         .alloc_payload (alloc_payload),
         .alloc_tags    (alloc_src_tag),
         .alloc_rdy     (alloc_src_rdy),
         .wk_valid      (wk_valid),
         .wk_tag        (wk_tag),
         .wk_early      (wk_early),
         .grant         (grant[e]),
         .valid         (valid[e]),
         .payload       (ent_payload[e]),
         .all_ready     (ready_mask[e]),
         .spec_ok       (spec_mask[e])
      );
   end

   // Tier choice: fully ready first, early-announced second
   assign any_ready = |ready_mask;
   assign pick_req  = any_ready ? ready_mask : spec_mask;

   rs_age_matrix #(.N(NUM_ENTRIES)) u_age (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_we (alloc_we),
      .valid    (valid),
      .req      (pick_req),
      .oldest   (grant)
   );

   always_comb begin
      disp_payload = '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
         disp_payload = disp_payload | (ent_payload[e] & {PAYLOAD_W{grant[e]}});
      end
   end

   assign disp_valid = |grant;
   assign disp_spec  = disp_valid && !any_ready;

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R2

   AST_READY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      any_ready |-> ((grant & ~ready_mask) == '0)); // R4

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_full && !flush && !disp_valid) |=> alloc_full); // R1

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!disp_valid && !alloc_full)); // R8

endmodule

// File: tb/sim_rs_station.sv
module sim_rs_station;

   localparam int N   = 4;
   localparam int NS  = 2;
   localparam int TW  = 4;
   localparam int PW  = 8;
   localparam int NV  = 27;

   typedef struct packed {
      logic          a;
      logic [PW-1:0] pay;
      logic [TW-1:0] t0;
      logic          r0;
      logic          wk;
      logic [TW-1:0] wtag;
      logic          early;
      logic          fl;
      logic          dv;
      logic [PW-1:0] epay;
      logic          espec;
      logic          efull;
   } vec_t;

   function automatic vec_t row(input logic a, input logic [PW-1:0] pay, input logic [TW-1:0] t0,
                                input logic r0, input logic wk, input logic [TW-1:0] wtag,
                                input logic early, input logic fl, input logic dv,
                                input logic [PW-1:0] epay, input logic espec, input logic efull);
      vec_t v;
      v.a = a; v.pay = pay; v.t0 = t0; v.r0 = r0; v.wk = wk; v.wtag = wtag;
      v.early = early; v.fl = fl; v.dv = dv; v.epay = epay; v.espec = espec; v.efull = efull;
      return v;
   endfunction

   // Inputs applied for one edge; expectations sampled at the following falling edge
   localparam vec_t VEC [NV] = '{
      row(1, 8'h11,  3, 0, 0,  0, 0, 0, 0, 8'h00, 0, 0),
      row(1, 8'h22,  0, 1, 0,  0, 0, 0, 1, 8'h22, 0, 0),
      row(1, 8'h33,  5, 0, 0,  0, 0, 0, 0, 8'h00, 0, 0),
      row(0, 8'h00,  0, 0, 1,  5, 0, 0, 1, 8'h33, 0, 0),
      row(1, 8'h44,  0, 1, 1,  3, 0, 0, 1, 8'h11, 0, 0),
      row(0, 8'h00,  0, 0, 0,  0, 0, 0, 1, 8'h44, 0, 0),
      row(0, 8'h00,  0, 0, 0,  0, 0, 0, 0, 8'h00, 0, 0),
      row(1, 8'h55,  7, 0, 0,  0, 0, 0, 0, 8'h00, 0, 0),
      row(1, 8'h66,  0, 1, 1,  7, 1, 0, 1, 8'h66, 0, 0),
      row(0, 8'h00,  0, 0, 0,  0, 0, 0, 1, 8'h55, 0, 0),
      row(1, 8'h77,  9, 0, 1,  9, 1, 0, 1, 8'h77, 1, 0),
      row(0, 8'h00,  0, 0, 0,  0, 0, 0, 0, 8'h00, 0, 0),
      row(1, 8'h88, 10, 0, 1, 10, 0, 0, 1, 8'h88, 0, 0),
      row(1, 8'h91, 12, 0, 0,  0, 0, 0, 0, 8'h00, 0, 0),
      row(1, 8'h92, 12, 0, 0,  0, 0, 0, 0, 8'h00, 0, 0),
      row(1, 8'h93, 12, 0, 0,  0, 0, 0, 0, 8'h00, 0, 0),
      row(1, 8'h94, 12, 0, 0,  0, 0, 0, 0, 8'h00, 0, 1),
      row(1, 8'h95,  0, 1, 0,  0, 0, 0, 0, 8'h00, 0, 1),
      row(0, 8'h00,  0, 0, 1, 12, 0, 0, 1, 8'h91, 0, 1),
      row(0, 8'h00,  0, 0, 0,  0, 0, 0, 1, 8'h92, 0, 0),
      row(0, 8'h00,  0, 0, 0,  0, 0, 0, 1, 8'h93, 0, 0),
      row(0, 8'h00,  0, 0, 0,  0, 0, 0, 1, 8'h94, 0, 0),
      row(0, 8'h00,  0, 0, 0,  0, 0, 0, 0, 8'h00, 0, 0),
      row(1, 8'hA1, 14, 0, 0,  0, 0, 0, 0, 8'h00, 0, 0),
      row(1, 8'hA2,  0, 1, 0,  0, 0, 1, 0, 8'h00, 0, 0),
      row(0, 8'h00,  0, 0, 1, 14, 0, 0, 0, 8'h00, 0, 0),
      row(0, 8'h00,  0, 0, 0,  0, 0, 0, 0, 8'h00, 0, 0)
   };

   // Requirement exercised by each row
   localparam string REQ [NV] = '{
      "R1", "R2", "R2", "R5", "R3", "R3", "R2", "R1", "R4", "R6",
      "R7", "R6", "R7", "R1", "R1", "R1", "R1", "R1", "R3", "R3",
      "R3", "R3", "R1", "R8", "R8", "R8", "R8"
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           flush = 1'b0;
   logic           alloc_valid = 1'b0;
   logic [PW-1:0]  alloc_payload = '0;
   logic [NS*TW-1:0] alloc_src_tag = '0;
   logic [NS-1:0]  alloc_src_rdy = '0;
   logic           alloc_full;
   logic           wk_valid = 1'b0;
   logic [TW-1:0]  wk_tag = '0;
   logic           wk_early = 1'b0;
   logic           disp_valid;
   logic [PW-1:0]  disp_payload;
   logic           disp_spec;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   rs_station #(
      .NUM_ENTRIES (N),
      .NUM_SRC     (NS),
      .TAG_W       (TW),
      .PAYLOAD_W   (PW)
   ) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush         (flush),
      .alloc_valid   (alloc_valid),
      .alloc_payload (alloc_payload),
      .alloc_src_tag (alloc_src_tag),
      .alloc_src_rdy (alloc_src_rdy),
      .alloc_full    (alloc_full),
      .wk_valid      (wk_valid),
      .wk_tag        (wk_tag),
      .wk_early      (wk_early),
      .disp_valid    (disp_valid),
      .disp_payload  (disp_payload),
      .disp_spec     (disp_spec)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      alloc_valid   = v.a;
      alloc_payload = v.pay;
      alloc_src_tag = {{TW{1'b0}}, v.t0};
      alloc_src_rdy = {1'b1, v.r0};
      wk_valid      = v.wk;
      wk_tag        = v.wtag;
      wk_early      = v.early;
      flush         = v.fl;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9", "disp_valid in reset", int'(disp_valid), 0);
      check("R9", "alloc_full in reset", int'(alloc_full), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9", "disp_valid after reset", int'(disp_valid), 0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         @(posedge clk);
         @(negedge clk);
         check(REQ[i], $sformatf("row %0d disp_valid", i), int'(disp_valid), int'(VEC[i].dv));
         check(REQ[i], $sformatf("row %0d alloc_full", i), int'(alloc_full), int'(VEC[i].efull));
         if (VEC[i].dv) begin
            check(REQ[i], $sformatf("row %0d disp_payload", i), int'(disp_payload), int'(VEC[i].epay));
            check(REQ[i], $sformatf("row %0d disp_spec", i), int'(disp_spec), int'(VEC[i].espec));
         end
      end

      // R9: reset in the middle of operation empties the station
      drive(row(1, 8'hC3, 0, 1, 0, 0, 0, 0, 0, 8'h00, 0, 0));
      @(posedge clk);
      @(negedge clk);
      check("R2", "held op before reset", int'(disp_payload), 8'hC3);
      drive(row(1, 8'hC4, 6, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0));
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      drive(row(0, 8'h00, 0, 0, 1, 6, 0, 0, 0, 8'h00, 0, 0));
      @(posedge clk);
      @(negedge clk);
      check("R9", "disp_valid after mid reset", int'(disp_valid), 0);
      check("R9", "alloc_full after mid reset", int'(alloc_full), 0);

      finish_run();
   end

endmodule